// File: doc/BRIEF.md
# Modem Line Change Detector

This block watches four incoming modem handshake lines (carrier detect, ring indicator, data-set-ready and clear-to-send), brings each into the local clock domain through a short synchronizer chain, and presents their present levels next to four sticky change flags in a single 9-bit status word. Carrier, data-set-ready and clear-to-send flag any transition. The ring flag is set only when the ring line drops from asserted to deasserted. Software clears flags by writing ones to them.

Whenever any flag goes from clear to set, the block emits a one-cycle change pulse that the interrupt logic uses as its modem-status source. The status word also carries one mode bit that software can read and write; its meaning belongs to the flow-control logic outside this block.

Status word layout: bit 8 mode, bit 7 carrier level, bit 6 ring level, bit 5 data-set-ready level, bit 4 clear-to-send level, bit 3 carrier changed, bit 2 ring trailing edge, bit 1 data-set-ready changed, bit 0 clear-to-send changed. Line input index: 0 clear-to-send, 1 data-set-ready, 2 ring, 3 carrier; all lines are active high at the port.

Top module: `mdm_line_watch`

## Requirements
- R1: While and after synchronous active-high reset, status bits 8 and 3:0 read 0 and the change pulse is 0.
- R2: Status bits 7:4 show line_i[3:0] after SYNC_STAGES rising clock edges, and not before.
- R3: A rise or a fall on line_i[0], line_i[1] or line_i[3] sets status bit 0, 1 or 3 respectively, SYNC_STAGES+1 edges after the line changes.
- R4: Status bit 2 is set only by line_i[2] going from 1 to 0; a rise of line_i[2] sets no flag.
- R5: Flags stay set through further line activity until cleared.
- R6: A cycle with wr_en_i high clears each flag i (0..3) for which wr_clr_i[i] is 1 and leaves the others unchanged.
- R7: A cycle with wr_en_i high loads wr_mode_i into status bit 8, which holds its value otherwise.
- R8: chg_pulse_o is high for exactly one cycle, in the cycle a flag goes from 0 to 1, and in no other cycle; several flags rising together give one pulse.
- R9: If a flag's edge is detected in the same cycle as a clear of that flag, the flag stays set.
- R10: Lines held at any fixed level through reset and afterwards cause no flag and no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| line_i | input | 4 | Raw modem lines: 0 CTS, 1 DSR, 2 ring, 3 carrier |
| wr_en_i | input | 1 | Status write strobe |
| wr_mode_i | input | 1 | Value for the mode bit |
| wr_clr_i | input | 4 | Write-one-to-clear mask for flags 3:0 |
| stat_o | output | 9 | Status word |
| chg_pulse_o | output | 1 | One-cycle pulse on any flag rising |

## Verification
The bench builds the block with the default two-stage synchronizer, so each line change reaches the level bits after two edges and the flags after three, which the directed latency tests probe edge by edge. With that depth the clear-collision case can be aimed at the exact edge where the detector fires, and reset can be applied with all lines high to show that the synchronizer preload suppresses false edges.

// File: rtl/mdm_watch_pkg.sv
package mdm_watch_pkg;
  localparam int NUM_LINES = 4;
  localparam int IDX_CTS   = 0;
  localparam int IDX_DSR   = 1;
  localparam int IDX_RING  = 2;
  localparam int IDX_DCD   = 3;
  localparam int STAT_W    = 2 * NUM_LINES + 1;
  localparam int MODE_BIT  = STAT_W - 1;

  typedef logic [NUM_LINES-1:0] line_vec_t;

  typedef struct packed {
    logic      mode;
    line_vec_t level;
    line_vec_t flag;
  } stat_word_t;
endpackage

// File: rtl/mdm_sync_cell.sv
module mdm_sync_cell #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // Reset preloads the chain with the present level so no edge is seen later.
  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= {STAGES{d_i}};
    else       chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_edge_detect.sv
module mdm_edge_detect
  import mdm_watch_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  line_vec_t lvl_i,
  output line_vec_t set_o
);
  line_vec_t prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= lvl_i;
    else       prev_q <= lvl_i;
  end

  // Ring flags only on its falling edge; the others flag either direction.
  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_line
      if (g == IDX_RING) begin : g_trail
        assign set_o[g] = prev_q[g] & ~lvl_i[g] & ~rst_i;
      end else begin : g_any
        assign set_o[g] = (prev_q[g] ^ lvl_i[g]) & ~rst_i;
      end
    end
  endgenerate
endmodule

// File: rtl/mdm_flag_bank.sv
module mdm_flag_bank
  import mdm_watch_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  line_vec_t set_i,
  input  line_vec_t clr_i,
  output line_vec_t flags_o,
  output logic      pulse_o
);
  line_vec_t flags_q;
  logic      pulse_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flags_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      // Set wins over clear in the same cycle.
      flags_q <= (flags_q & ~clr_i) | set_i;
      pulse_q <= |(set_i & ~flags_q);
    end
  end

  assign flags_o = flags_q;
  assign pulse_o = pulse_q;

  AST_PULSE_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    (|(flags_q & ~$past(flags_q))) |-> pulse_q); // R8

  AST_PULSE_ONLY_ON_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_q |-> (|(flags_q & ~$past(flags_q)))); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    !(|($past(flags_q) & ~flags_q & ~$past(clr_i)))); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    !(|($past(set_i & clr_i) & ~flags_q))); // R9
endmodule

// File: rtl/mdm_line_watch.sv
module mdm_line_watch
  import mdm_watch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [3:0] line_i,
  input  logic       wr_en_i,
  input  logic       wr_mode_i,
  input  logic [3:0] wr_clr_i,
  output logic [8:0] stat_o,
  output logic       chg_pulse_o
);
  line_vec_t  lvl_sync;
  line_vec_t  set_vec;
  line_vec_t  clr_vec;
  line_vec_t  flags;
  logic       mode_q;
  stat_word_t word;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_sync
      mdm_sync_cell #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (line_i[g]),
        .q_o   (lvl_sync[g])
      );
    end
  endgenerate

  mdm_edge_detect i_edge (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .lvl_i (lvl_sync),
    .set_o (set_vec)
  );

  assign clr_vec = wr_en_i ? wr_clr_i : '0;

  mdm_flag_bank i_flags (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags),
    .pulse_o (chg_pulse_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)        mode_q <= 1'b0;
    else if (wr_en_i) mode_q <= wr_mode_i;
  end

  assign word.mode  = mode_q;
  assign word.level = lvl_sync;
  assign word.flag  = flags;
  assign stat_o     = word;

  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(wr_en_i) |-> (stat_o[MODE_BIT] == $past(wr_mode_i))); // R7

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(wr_en_i) |-> $stable(stat_o[MODE_BIT])); // R7

  AST_RING_TRAIL_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(flags[IDX_RING]) |-> (!$past(lvl_sync[IDX_RING]) && $past(lvl_sync[IDX_RING], 2))); // R4
endmodule

// File: tb/test_mdm_line_watch.sv
`timescale 1ns/1ps
module test_mdm_line_watch;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] line;
  logic       wr_en;
  logic       wr_mode;
  logic [3:0] wr_clr;
  logic [8:0] stat;
  logic       pulse;

  int n_chk  = 0;
  int n_bad  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mdm_line_watch #(.SYNC_STAGES(2)) i_mdm_line_watch (
    .clk_i       (clk),
    .rst_i       (rst),
    .line_i      (line),
    .wr_en_i     (wr_en),
    .wr_mode_i   (wr_mode),
    .wr_clr_i    (wr_clr),
    .stat_o      (stat),
    .chg_pulse_o (pulse)
  );

  always @(negedge clk) if (pulse) pulses++;

  // lines, write enable, write data (bit 8 mode, 3:0 clear), expected status, expected pulses
  typedef struct packed {
    logic [3:0] ln;
    logic       we;
    logic [8:0] wd;
    logic [8:0] exp;
    logic [1:0] np;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{4'b0001, 1'b0, 9'h000, 9'h011, 2'd1}, // R3 cts rise
    '{4'b0001, 1'b1, 9'h001, 9'h010, 2'd0}, // R6 clear cts
    '{4'b0101, 1'b0, 9'h000, 9'h050, 2'd0}, // R4 ring rise ignored
    '{4'b0001, 1'b0, 9'h000, 9'h014, 2'd1}, // R4 ring fall
    '{4'b1011, 1'b0, 9'h000, 9'h0BE, 2'd1}, // R3 R8 two flags one pulse
    '{4'b0000, 1'b0, 9'h000, 9'h00F, 2'd1}, // R5 sticky
    '{4'b0000, 1'b1, 9'h105, 9'h10A, 2'd0}, // R6 R7 partial clear + mode
    '{4'b0000, 1'b1, 9'h000, 9'h00A, 2'd0}, // R7 mode back, R6 no clear
    '{4'b0000, 1'b1, 9'h00A, 9'h000, 2'd0}, // R6 clear rest
    '{4'b0100, 1'b1, 9'h100, 9'h140, 2'd0}, // R4 R7
    '{4'b0100, 1'b0, 9'h000, 9'h140, 2'd0}  // R7 hold
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] lv);
    @(negedge clk);
    rst = 1'b1; line = lv; wr_en = 1'b0; wr_mode = 1'b0; wr_clr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 status in reset", {stat[8], 4'b0, stat[3:0]}, 9'h000);
    check("R1 pulse in reset", {8'b0, pulse}, 9'h000);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; line = '0; wr_en = 1'b0; wr_mode = 1'b0; wr_clr = '0;
    do_reset(4'b0000);
    @(negedge clk);
    check("R1 status after reset", stat, 9'h000);
    check("R1 pulse after reset", {8'b0, pulse}, 9'h000);

    // Vector table
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      pulses = 0;
      line = VEC[i].ln; wr_en = VEC[i].we; wr_mode = VEC[i].wd[8]; wr_clr = VEC[i].wd[3:0];
      @(negedge clk);
      wr_en = 1'b0;
      repeat (4) @(negedge clk);
      check($sformatf("R3-table step %0d status", i), stat, VEC[i].exp);
      check($sformatf("R8 step %0d pulse count", i), 9'(pulses), 9'(VEC[i].np));
    end

    // R2 / R3 / R8 latency, edge by edge (state: lines 0100, status 9'h140)
    @(negedge clk);
    line = 4'b0101;
    @(negedge clk);
    check("R2 level not yet after one edge", {8'b0, stat[4]}, 9'h000);
    @(negedge clk);
    check("R2 level after two edges", {8'b0, stat[4]}, 9'h001);
    check("R3 flag not yet after two edges", {8'b0, stat[0]}, 9'h000);
    @(negedge clk);
    check("R3 flag after three edges", {8'b0, stat[0]}, 9'h001);
    check("R8 pulse in flag cycle", {8'b0, pulse}, 9'h001);
    @(negedge clk);
    check("R8 pulse lasts one cycle", {8'b0, pulse}, 9'h000);

    // R9: clear the cts flag on the edge that re-detects a cts change
    pulses = 0;
    line = 4'b0100;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = 1'b1; wr_clr = 4'b0001;
    @(negedge clk);
    wr_en = 1'b0; wr_clr = '0;
    check("R9 flag survives colliding clear", {8'b0, stat[0]}, 9'h001);
    @(negedge clk);
    check("R9 no pulse for already set flag", 9'(pulses), 9'h000);

    // R10: reset with all lines high
    do_reset(4'b1111);
    pulses = 0;
    @(negedge clk);
    check("R10 levels at reset release", stat, 9'h0F0);
    repeat (6) @(negedge clk);
    check("R10 no flags with steady lines", stat, 9'h0F0);
    check("R10 no pulse with steady lines", 9'(pulses), 9'h000);

    // R4 after reset: ring fall flags
    line = 4'b1011;
    repeat (4) @(negedge clk);
    check("R4 ring fall after reset", stat, 9'h0B4);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule